// File: doc/BRIEF.md
# Instruction Prefetch Queue Bus Unit

This block sits between an instruction-execution pipeline and a memory bus. It fetches instruction bytes ahead of need and keeps them in a short byte queue. The memory side can be a byte bus or an aligned 16-bit bus, chosen by a parameter, and the queue depth follows that choice. Each bus fetch lasts a fixed number of clocks. When a parameter enables it, an address region below 64 KB is treated as shared memory, and each fetch from that region takes longer. A memory-ready input can stretch any fetch further.

The execution side sees the byte at the head of the queue together with a valid flag. It asks for a byte by holding a request. A byte is taken on each clock in which the request and the valid flag are both high. A request that finds the queue empty counts as a stall cycle, and a running counter totals these. On a taken branch the execution side pulses a flush with a new address. The queue is then emptied at once, any fetch in flight is dropped, and fetching starts again at the new address. A bus-busy input, raised by operand traffic elsewhere, holds back new prefetches. It does not cut short a fetch that is already running.

Top module: `pfq_prefetch_unit`

## Requirements
- R1: The queue holds at most 4 bytes with the byte bus (WIDE=0) and 6 bytes with the 16-bit bus (WIDE=1). Once full, it issues no further fetch.
- R2: Outside the shared region, a fetch keeps mem_req high for 4 clocks. On the byte bus it delivers mem_rdata[7:0]. On the 16-bit bus it delivers the aligned word: bits 7:0 are queued first, then bits 15:8.
- R3: With SLOW_EN=1, a fetch whose address is below 0x10000 lasts 6 clocks instead of 4.
- R4: A fetch starts only when the queue space left after the same clock's pop and fill is at least the width of that fetch (1 byte, or 2 bytes for an even word).
- R5: On the 16-bit bus, a fetch from an odd address queues only mem_rdata[15:8]. Later fetches use even addresses.
- R6: A flush empties the queue at that clock edge and drops any fetch in flight (mem_req low in the next cycle). The first fetch at the new address starts on the following edge.
- R7: While bus_busy is high, no fetch starts. A fetch already running completes and queues its data.
- R8: q_byte and q_valid show the oldest queued byte, and bytes leave in address order. A pop and a fill on the same edge are both applied.
- R9: stall_cnt increments by one on each clock with pop_req high and q_valid low, and stays unchanged on all other clocks.
- R10: During reset, q_valid, q_count, stall_cnt and mem_req are all zero.
- R11: A fetch does not complete while mem_ready is low. mem_req stays high until the edge at which mem_ready is high and the minimum length has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty queue and restart fetching at flush_addr |
| flush_addr | input | ADDR_W | Restart fetch address |
| pop_req | input | 1 | Execution side wants a byte this clock |
| q_valid | output | 1 | Head byte is valid |
| q_byte | output | 8 | Head-of-queue byte |
| q_count | output | CNT_W | Bytes held in the queue |
| stall_cnt | output | STALL_W | Running count of starved request cycles |
| bus_busy | input | 1 | Operand traffic owns the bus; blocks new fetches |
| mem_req | output | 1 | Fetch bus cycle in progress |
| mem_addr | output | ADDR_W | Fetch address (word aligned on the 16-bit bus) |
| mem_rdata | input | DW | Fetch data, sampled on the completing edge |
| mem_ready | input | 1 | Memory may complete the current fetch |

## Verification
The main function is driven by a table of flush-then-consume streams. Each stream starts at a different address and holds pop_req high until a given number of bytes has been taken. Every popped byte is compared with the memory pattern, and the stall total is compared with a value derived by hand from the fetch length and the bus width. A stream in fast memory and one in the shared region tell the 4-clock fetch from the 6-clock one. A stream that crosses 0x10000 shows the fetch length changing partway through. Even and odd starts on the 16-bit bus show word delivery apart from single upper-byte delivery.

Directed cases then cover the remaining behaviour:
- filling with no consumer, where an odd start on the 16-bit bus must stop at 5 bytes;
- a flush in the middle of a fetch;
- bus_busy raised before a fetch and raised during one;
- a stretched ready;
- a pop that lands on the same edge as a fill.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
   // Queue depth follows the bus width selection.
   function automatic int qdepth(input int wide);
      return (wide != 0) ? 6 : 4;
   endfunction
endpackage

// File: rtl/pfq_byte_queue.sv
module pfq_byte_queue #(
   parameter int DEPTH = 4,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [1:0]       push_n,
   input  logic [7:0]       push_d0,
   input  logic [7:0]       push_d1,
   input  logic             pop,
   output logic [7:0]       head,
   output logic [CNT_W-1:0] count
);
   logic [7:0]       store [DEPTH];
   logic [PTR_W-1:0] rd_p, wr_p;

   function automatic logic [PTR_W-1:0] wrap(input logic [PTR_W-1:0] p, input int k);
      int t;
      t = int'(p) + k;
      if (t >= DEPTH) t = t - DEPTH;
      return PTR_W'(t);
   endfunction

   always_ff @(posedge clk) begin
      if (push_n != 2'd0) store[wr_p] <= push_d0;
      if (push_n == 2'd2) store[wrap(wr_p, 1)] <= push_d1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         rd_p  <= '0;
         wr_p  <= '0;
         count <= '0;
      end else begin
         if (pop) rd_p <= wrap(rd_p, 1);
         wr_p  <= wrap(wr_p, int'(push_n));
         count <= count + CNT_W'(push_n) - CNT_W'(pop);
      end
   end

   assign head = store[rd_p];

   // R1
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));
   // R8
   pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> count != '0);
   // R6
   clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> count == '0);
endmodule

// File: rtl/pfq_bus_seq.sv
module pfq_bus_seq #(
   parameter int ADDR_W     = 20,
   parameter int WIDE       = 0,
   parameter int SLOW_EN    = 1,
   parameter int SLOW_LIMIT = 65536,
   parameter int FAST_CLKS  = 4,
   parameter int SLOW_CLKS  = 6,
   parameter int ROOM_W     = 3,
   parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
   localparam int TICK_W = $clog2(((SLOW_CLKS > FAST_CLKS) ? SLOW_CLKS : FAST_CLKS) + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [ADDR_W-1:0] flush_addr,
   input  logic              bus_busy,
   input  logic              mem_ready,
   input  logic [ROOM_W-1:0] room,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              done,
   output logic              cur_odd,
   output logic [1:0]        cur_w
);
   logic              busy;
   logic [TICK_W-1:0] tick, len;
   logic [ADDR_W-1:0] ptr, nxt;
   logic [1:0]        nxt_w;
   logic              slow, start;

   assign slow = (SLOW_EN != 0) && (ptr < ADDR_W'(SLOW_LIMIT));
   assign len  = slow ? TICK_W'(SLOW_CLKS) : TICK_W'(FAST_CLKS);
   assign done = busy && (tick == len) && mem_ready;
   assign nxt  = done ? ptr + ADDR_W'(cur_w) : ptr;

   generate
      if (WIDE != 0) begin : g_word
         assign cur_w    = ptr[0] ? 2'd1 : 2'd2;
         assign nxt_w    = nxt[0] ? 2'd1 : 2'd2;
         assign mem_addr = {ptr[ADDR_W-1:1], 1'b0};
      end else begin : g_byte
         assign cur_w    = 2'd1;
         assign nxt_w    = 2'd1;
         assign mem_addr = ptr;
      end
   endgenerate

   assign cur_odd = ptr[0];
   assign start   = (!busy || done) && !flush && !bus_busy && (room >= ROOM_W'(nxt_w));
   assign mem_req = busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         tick <= '0;
         ptr  <= RESET_ADDR;
      end else if (flush) begin
         busy <= 1'b0;
         tick <= '0;
         ptr  <= flush_addr;
      end else begin
         ptr <= nxt;
         if (start) begin
            busy <= 1'b1;
            tick <= TICK_W'(1);
         end else if (done) begin
            busy <= 1'b0;
         end else if (busy && tick != len) begin
            tick <= tick + 1'b1;
         end
      end
   end

   // R11
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !done && !flush) |=> (mem_req && $stable(mem_addr)));
   // R7
   busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_req && bus_busy) |=> !mem_req);
   // R6
   flush_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !mem_req);
endmodule

// File: rtl/pfq_stall_meter.sv
module pfq_stall_meter #(
   parameter int STALL_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               want,
   input  logic               have,
   output logic [STALL_W-1:0] total
);
   always_ff @(posedge clk) begin
      if (!rst_n)            total <= '0;
      else if (want && !have) total <= total + 1'b1;
   end

   // R9
   stall_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (want && !have) |=> (total == $past(total) + 1'b1));
   // R9
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(want && !have) |=> $stable(total));
endmodule

// File: rtl/pfq_prefetch_unit.sv
module pfq_prefetch_unit #(
   parameter int ADDR_W     = 20,
   parameter int WIDE       = 0,
   parameter int SLOW_EN    = 1,
   parameter int SLOW_LIMIT = 65536,
   parameter int FAST_CLKS  = 4,
   parameter int SLOW_CLKS  = 6,
   parameter int STALL_W    = 32,
   localparam int DEPTH = pfq_pkg::qdepth(WIDE),
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int DW    = (WIDE != 0) ? 16 : 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic [ADDR_W-1:0]  flush_addr,
   input  logic               pop_req,
   output logic               q_valid,
   output logic [7:0]         q_byte,
   output logic [CNT_W-1:0]   q_count,
   output logic [STALL_W-1:0] stall_cnt,
   input  logic               bus_busy,
   output logic               mem_req,
   output logic [ADDR_W-1:0]  mem_addr,
   input  logic [DW-1:0]      mem_rdata,
   input  logic               mem_ready
);
   generate
      if (WIDE != 0 && WIDE != 1) begin : g_bad_wide
         $error("WIDE must be 0 or 1");
      end
      if (ADDR_W < 17) begin : g_bad_addr
         $error("ADDR_W must cover the shared region limit");
      end
      if (FAST_CLKS < 1 || SLOW_CLKS < 1) begin : g_bad_clks
         $error("bus cycle lengths must be positive");
      end
   endgenerate

   logic             done, cur_odd, pop_fire;
   logic [1:0]       cur_w, push_n;
   logic [7:0]       d0, d1;
   logic [CNT_W:0]   after, room;

   assign q_valid  = (q_count != '0);
   assign pop_fire = pop_req && q_valid && !flush;
   assign push_n   = (done && !flush) ? cur_w : 2'd0;
   assign after    = {1'b0, q_count} + (CNT_W+1)'(push_n) - (CNT_W+1)'(pop_fire);
   assign room     = (CNT_W+1)'(DEPTH) - after;

   generate
      if (WIDE != 0) begin : g_steer16
         assign d0 = cur_odd ? mem_rdata[DW-1:DW-8] : mem_rdata[7:0];
         assign d1 = mem_rdata[DW-1:DW-8];
      end else begin : g_steer8
         assign d0 = mem_rdata[7:0];
         assign d1 = mem_rdata[7:0];
      end
   endgenerate

   pfq_bus_seq #(
      .ADDR_W(ADDR_W), .WIDE(WIDE), .SLOW_EN(SLOW_EN), .SLOW_LIMIT(SLOW_LIMIT),
      .FAST_CLKS(FAST_CLKS), .SLOW_CLKS(SLOW_CLKS), .ROOM_W(CNT_W+1),
      .RESET_ADDR('0)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
      .bus_busy(bus_busy), .mem_ready(mem_ready), .room(room),
      .mem_req(mem_req), .mem_addr(mem_addr), .done(done),
      .cur_odd(cur_odd), .cur_w(cur_w)
   );

   pfq_byte_queue #(.DEPTH(DEPTH)) u_queue (
      .clk(clk), .rst_n(rst_n), .clear(flush), .push_n(push_n),
      .push_d0(d0), .push_d1(d1), .pop(pop_fire),
      .head(q_byte), .count(q_count)
   );

   pfq_stall_meter #(.STALL_W(STALL_W)) u_stall (
      .clk(clk), .rst_n(rst_n), .want(pop_req), .have(q_valid), .total(stall_cnt)
   );

   // R4
   room_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> (q_count <= CNT_W'(DEPTH - int'(cur_w))));
   // R8
   order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_valid && !pop_req && !flush) |=> (q_valid && $stable(q_byte)));
endmodule

// File: tb/tb_pfq_prefetch_unit.sv
module tb_pfq_prefetch_unit;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n = 1'b0, flush = 1'b0, pop_req = 1'b0, bus_busy = 1'b0, mem_ready = 1'b1;
   logic [19:0] flush_addr = '0;

   logic        q_valid, mreq;
   logic [7:0]  q_byte;
   logic [2:0]  q_count;
   logic [31:0] stall_cnt;
   logic [19:0] maddr;
   logic        w_valid, w_mreq;
   logic [7:0]  w_byte;
   logic [2:0]  w_count;
   logic [31:0] w_stall;
   logic [19:0] w_maddr;

   int checks = 0, fails = 0;

   function automatic logic [7:0] pat(input logic [19:0] a);
      return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'h3C;
   endfunction

   pfq_prefetch_unit #(.WIDE(0), .SLOW_EN(1)) dut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr), .pop_req(pop_req),
      .q_valid(q_valid), .q_byte(q_byte), .q_count(q_count), .stall_cnt(stall_cnt),
      .bus_busy(bus_busy), .mem_req(mreq), .mem_addr(maddr), .mem_rdata(pat(maddr)),
      .mem_ready(mem_ready));

   pfq_prefetch_unit #(.WIDE(1), .SLOW_EN(0)) dut_w (
      .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr), .pop_req(pop_req),
      .q_valid(w_valid), .q_byte(w_byte), .q_count(w_count), .stall_cnt(w_stall),
      .bus_busy(bus_busy), .mem_req(w_mreq), .mem_addr(w_maddr),
      .mem_rdata({pat(w_maddr | 20'h1), pat(w_maddr)}), .mem_ready(mem_ready));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // Returns at the negedge just after the flush edge.
   task automatic do_flush(input logic [19:0] a);
      flush_addr = a;
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
   endtask

   // sel(1) addr(20) nbytes(4) expected stall(8)
   localparam logic [32:0] VEC [6] = '{
      {1'b0, 20'h20000, 4'd4, 8'd14},   // R2 fast byte bus
      {1'b0, 20'h00100, 4'd4, 8'd22},   // R3 shared region
      {1'b0, 20'h0FFFE, 4'd4, 8'd18},   // R3 crossing region edge
      {1'b1, 20'h20000, 4'd4, 8'd7},    // R2 word bus even
      {1'b1, 20'h20001, 4'd3, 8'd8},    // R5 word bus odd start
      {1'b1, 20'h20000, 4'd6, 8'd9}     // R2 longer word stream
   };

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      logic [31:0] s0;
      int k, guard;
      wait_n(3);
      // R10 reset state
      chk("R10 valid", {31'd0, q_valid}, 32'd0);
      chk("R10 count", {29'd0, w_count}, 32'd0);
      chk("R10 stall", stall_cnt, 32'd0);
      chk("R10 req", {30'd0, mreq, w_mreq}, 32'd0);
      rst_n = 1'b1;
      wait_n(2);

      // R2 R3 R5 R8 R9 streams
      foreach (VEC[v]) begin
         logic        sel;
         logic [19:0] a;
         int          n;
         sel = VEC[v][32];
         a   = VEC[v][31:12];
         n   = int'(VEC[v][11:8]);
         do_flush(a);
         pop_req = 1'b1;
         s0 = sel ? w_stall : stall_cnt;
         k = 0; guard = 0;
         while (k < n && guard < 200) begin
            if (sel ? w_valid : q_valid) begin
               chk("R8 stream byte", {24'd0, sel ? w_byte : q_byte}, {24'd0, pat(a + 20'(k))});
               k++;
            end
            guard++;
            if (k < n) @(negedge clk);
         end
         @(negedge clk);
         pop_req = 1'b0;
         chk("R9 stall total", (sel ? w_stall : stall_cnt) - s0, {24'd0, VEC[v][7:0]});
      end

      // R1 fill to depth, then idle
      do_flush(20'h20000);
      s0 = stall_cnt;
      wait_n(40);
      chk("R1 depth byte", {29'd0, q_count}, 32'd4);
      chk("R1 depth word", {29'd0, w_count}, 32'd6);
      chk("R1 idle when full", {30'd0, mreq, w_mreq}, 32'd0);
      chk("R9 no stall idle", stall_cnt, s0);

      // R8 pop and fill on the same edge
      pop_req = 1'b1; @(negedge clk); pop_req = 1'b0;   // pop at e1, fetch starts
      wait_n(3);                                          // e2..e4
      pop_req = 1'b1; @(negedge clk); pop_req = 1'b0;   // e5: pop + fill
      chk("R8 count after pop+fill", {29'd0, q_count}, 32'd3);
      chk("R8 head after pop+fill", {24'd0, q_byte}, {24'd0, pat(20'h20002)});

      // R6 flush mid-fetch drops it and restarts
      wait_n(1);
      do_flush(20'h30010);
      chk("R6 emptied", {29'd0, q_count}, 32'd0);
      chk("R6 fetch dropped", {31'd0, mreq}, 32'd0);
      wait_n(4);
      chk("R6 not yet", {31'd0, q_valid}, 32'd0);
      wait_n(1);
      chk("R6 restart byte", {24'd0, q_byte}, {24'd0, pat(20'h30010)});
      chk("R6 restart word", {29'd0, w_count}, 32'd2);

      // R4 R5 odd start on word bus stops at 5
      do_flush(20'h20001);
      wait_n(40);
      chk("R4 odd fill", {29'd0, w_count}, 32'd5);
      chk("R4 no fetch", {31'd0, w_mreq}, 32'd0);
      chk("R5 odd head", {24'd0, w_byte}, {24'd0, pat(20'h20001)});

      // R7 bus_busy blocks start
      bus_busy = 1'b1;
      do_flush(20'h20000);
      wait_n(20);
      chk("R7 blocked", {29'd0, q_count}, 32'd0);
      chk("R7 no req", {30'd0, mreq, w_mreq}, 32'd0);
      bus_busy = 1'b0;
      // R7 busy mid-fetch does not abort
      do_flush(20'h20000);
      wait_n(2);
      bus_busy = 1'b1;
      wait_n(10);
      chk("R7 completes byte", {29'd0, q_count}, 32'd1);
      chk("R7 completes word", {29'd0, w_count}, 32'd2);
      bus_busy = 1'b0;

      // R11 ready stretches the fetch
      mem_ready = 1'b0;
      do_flush(20'h20000);
      wait_n(20);
      chk("R11 held", {29'd0, q_count}, 32'd0);
      chk("R11 req high", {31'd0, mreq}, 32'd1);
      mem_ready = 1'b1;
      @(negedge clk);
      chk("R11 completes", {29'd0, q_count}, 32'd1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule